// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a word-addressed scratchpad shared by a group of sixteen requesters that present their accesses together as one batch. Storage is split into sixteen single-ported banks, with consecutive word addresses placed in consecutive banks. A batch is either all reads or all writes. A per-lane enable mask selects which lanes take part.

For each batch the block finds the bank each active lane targets. When no bank sees two different addresses, the batch finishes in one pass. Lanes that share an address are merged into one bank access, so a broadcast read also finishes in one pass. When a bank sees several different addresses, the batch is split into passes. In each pass every bank serves the address of its lowest-numbered lane that is still waiting, and all waiting lanes with that same address are finished in that pass. Each pass takes two clock cycles.

When the last pass is done, the block raises a one-cycle completion pulse. The read data of every lane is presented with that pulse, together with the number of passes the batch needed. A surrounding pipeline can use the pass count to judge how well its access pattern spreads across the banks.

Top module: `banked_spad`

## Requirements
- R1: The bank of a lane is the low 4 bits of its word address and the row is the remaining upper bits. Data written at any address is read back unchanged from that same address.
- R2: A batch whose active lanes all target different banks finishes in exactly one pass.
- R3: A read batch in which every active lane uses the same address finishes in one pass, and every active lane receives that word.
- R4: The reported pass count equals the largest number of distinct addresses that active lanes map to any single bank. A word stride of 2 over 16 lanes gives 2 passes, and a stride of 8 gives 8 passes.
- R5: A non-empty batch raises the one-cycle completion pulse exactly 2 x (pass count) cycles after the acceptance edge.
- R6: Input ready is low from the cycle after a non-empty batch is accepted until the cycle of its completion pulse, and it is high again in that cycle.
- R7: When several active lanes of one write batch use the same address, the data of the highest-numbered of those lanes is stored.
- R8: Inactive lanes take no part in conflict counting, write nothing, and return zero read data.
- R9: A batch with an all-zero lane mask completes in the cycle after acceptance with a pass count of 0.
- R10: The pass count never exceeds 16, and it holds its value from a completion pulse until the next batch is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | A batch is presented |
| reqReady | output | 1 | The block can accept a batch |
| reqWrite | input | 1 | 1 = write batch, 0 = read batch |
| laneMask | input | 16 | Per-lane enable, bit i for lane i |
| laneAddr | input | 128 | Word address of lane i in bits [8i+7:8i] |
| laneWdata | input | 512 | Write data of lane i in bits [32i+31:32i] |
| doneValid | output | 1 | One-cycle completion pulse |
| rdData | output | 512 | Read data of lane i in bits [32i+31:32i], valid with doneValid |
| passCount | output | 5 | Passes used by the last finished batch |

## Verification
The checker watches the handshake and the timing on every cycle. It checks that ready drops after a non-empty batch is accepted and that completion only comes once the block is idle again. It counts busy cycles against twice the reported pass count, checks that an empty batch returns at once, and checks that the pass count stays in range and holds between batches. The per-bank grouping can only be seen in the bench scenarios: that the pass count matches the distinct-address count for strides and random masks, that merged lanes all get the broadcast word, that the highest lane wins a shared write, and that data survives the bank and row split. The bench compares these against a plain address-indexed model.

// File: rtl/spad_pkg.sv
package spad_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture a new batch
    logic select;  // pick the per-bank winners of the next pass
    logic access;  // perform the bank reads or writes of the pass
  } spadStrobe_t;
endpackage

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        maskEmpty,
  input  logic        lastPass,
  output logic        reqReady,
  output logic        doneValid,
  output spadStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_SEL, S_ACC} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        stateNext   = maskEmpty ? S_IDLE : S_SEL;
      end
      S_SEL: begin
        strobe.select = 1'b1;
        stateNext     = S_ACC;
      end
      S_ACC: begin
        strobe.access = 1'b1;
        stateNext     = lastPass ? S_IDLE : S_SEL;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      doneValid <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= ((state == S_IDLE) && reqValid && maskEmpty) ||
                   ((state == S_ACC) && lastPass);
    end
  end

  assign reqReady = (state == S_IDLE);
endmodule

// File: rtl/spad_datapath.sv
module spad_datapath
  import spad_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int BANKS      = 16,
  parameter int WORD_W     = 32,
  parameter int BANK_DEPTH = 16,
  localparam int BANK_W    = $clog2(BANKS),
  localparam int ROW_W     = $clog2(BANK_DEPTH),
  localparam int ADDR_W    = BANK_W + ROW_W,
  localparam int CNT_W     = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  spadStrobe_t               strobe,
  input  logic                      reqWrite,
  input  logic [LANES-1:0]          laneMask,
  input  logic [LANES*ADDR_W-1:0]   laneAddr,
  input  logic [LANES*WORD_W-1:0]   laneWdata,
  output logic                      maskEmpty,
  output logic                      lastPass,
  output logic [LANES*WORD_W-1:0]   rdData,
  output logic [CNT_W-1:0]          passCount
);
  logic              writeQ;
  logic [LANES-1:0]  pending, served, selMask;
  logic [ADDR_W-1:0] addrIn [LANES];
  logic [WORD_W-1:0] dataIn [LANES];
  logic [ADDR_W-1:0] addrQ  [LANES];
  logic [WORD_W-1:0] dataQ  [LANES];
  logic [WORD_W-1:0] rdQ    [LANES];

  logic [ADDR_W-1:0] leaderAddr [BANKS];
  logic [BANKS-1:0]  leaderHit;
  logic [BANKS-1:0]  bankEnQ;
  logic [ROW_W-1:0]  bankRowQ   [BANKS];
  logic [WORD_W-1:0] bankWdata  [BANKS];
  logic [WORD_W-1:0] bankRd     [BANKS];

  genvar gl, gb;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      assign addrIn[gl] = laneAddr[gl*ADDR_W +: ADDR_W];
      assign dataIn[gl] = laneWdata[gl*WORD_W +: WORD_W];
      assign rdData[gl*WORD_W +: WORD_W] = rdQ[gl];
    end
  endgenerate

  assign maskEmpty = (laneMask == '0);
  assign lastPass  = ((pending & ~selMask) == '0);

  // lowest-numbered pending lane of each bank sets that bank's address
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      leaderAddr[b] = '0;
      leaderHit[b]  = 1'b0;
      for (int j = LANES - 1; j >= 0; j--) begin
        if (pending[j] && (addrQ[j][BANK_W-1:0] == BANK_W'(b))) begin
          leaderAddr[b] = addrQ[j];
          leaderHit[b]  = 1'b1;
        end
      end
    end
  end

  // every pending lane sharing its bank leader's address joins the pass
  always_comb begin
    for (int i = 0; i < LANES; i++)
      served[i] = pending[i] && (addrQ[i] == leaderAddr[addrQ[i][BANK_W-1:0]]);
  end

  // write data per bank: later (higher) lanes override earlier ones
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bankWdata[b] = '0;
      for (int i = 0; i < LANES; i++)
        if (selMask[i] && (addrQ[i][BANK_W-1:0] == BANK_W'(b)))
          bankWdata[b] = dataQ[i];
    end
  end

  generate
    for (gb = 0; gb < BANKS; gb++) begin : g_bank
      logic [WORD_W-1:0] store [BANK_DEPTH];
      always_ff @(posedge clk) begin
        if (strobe.access && writeQ && bankEnQ[gb])
          store[bankRowQ[gb]] <= bankWdata[gb];
      end
      assign bankRd[gb] = store[bankRowQ[gb]];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeQ    <= 1'b0;
      pending   <= '0;
      selMask   <= '0;
      bankEnQ   <= '0;
      passCount <= '0;
      for (int i = 0; i < LANES; i++) begin
        addrQ[i] <= '0;
        dataQ[i] <= '0;
        rdQ[i]   <= '0;
      end
      for (int b = 0; b < BANKS; b++) bankRowQ[b] <= '0;
    end else begin
      if (strobe.load) begin
        writeQ    <= reqWrite;
        pending   <= laneMask;
        selMask   <= '0;
        passCount <= '0;
        for (int i = 0; i < LANES; i++) begin
          addrQ[i] <= addrIn[i];
          dataQ[i] <= dataIn[i];
          rdQ[i]   <= '0;
        end
      end
      if (strobe.select) begin
        selMask <= served;
        bankEnQ <= leaderHit;
        for (int b = 0; b < BANKS; b++)
          bankRowQ[b] <= leaderAddr[b][ADDR_W-1:BANK_W];
      end
      if (strobe.access) begin
        pending   <= pending & ~selMask;
        passCount <= passCount + 1'b1;
        if (!writeQ) begin
          for (int i = 0; i < LANES; i++)
            if (selMask[i]) rdQ[i] <= bankRd[addrQ[i][BANK_W-1:0]];
        end
      end
    end
  end
endmodule

// File: rtl/banked_spad.sv
module banked_spad
  import spad_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int BANKS      = 16,
  parameter int WORD_W     = 32,
  parameter int BANK_DEPTH = 16,
  localparam int ADDR_W    = $clog2(BANKS) + $clog2(BANK_DEPTH),
  localparam int CNT_W     = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [LANES-1:0]        laneMask,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  input  logic [LANES*WORD_W-1:0] laneWdata,
  output logic                    doneValid,
  output logic [LANES*WORD_W-1:0] rdData,
  output logic [CNT_W-1:0]        passCount
);
  spadStrobe_t strobe;
  logic        maskEmpty, lastPass;

  spad_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .maskEmpty (maskEmpty),
    .lastPass  (lastPass),
    .reqReady  (reqReady),
    .doneValid (doneValid),
    .strobe    (strobe)
  );

  spad_datapath #(
    .LANES(LANES), .BANKS(BANKS), .WORD_W(WORD_W), .BANK_DEPTH(BANK_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .laneMask  (laneMask),
    .laneAddr  (laneAddr),
    .laneWdata (laneWdata),
    .maskEmpty (maskEmpty),
    .lastPass  (lastPass),
    .rdData    (rdData),
    .passCount (passCount)
  );
endmodule

// File: rtl/spad_checks.sv
module spad_checks #(
  parameter int LANES = 16,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [LANES-1:0] laneMask,
  input logic             doneValid,
  input logic [CNT_W-1:0] passCount
);
  logic       fire;
  logic [7:0] busyCnt;
  assign fire = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyCnt <= '0;
    else if (fire)      busyCnt <= '0;
    else if (!reqReady) busyCnt <= busyCnt + 1'b1;
  end

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    fire && (laneMask != '0) |=> !reqReady);

  a_r6_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> reqReady);

  a_r5_latency_matches_passes: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (9'(busyCnt) == 9'(2 * passCount)));

  a_r9_empty_batch_immediate: assert property (@(posedge clk) disable iff (!rstN)
    fire && (laneMask == '0) |=> doneValid && (passCount == '0));

  a_r10_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    passCount <= CNT_W'(LANES));

  a_r10_count_holds_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && !fire |=> $stable(passCount));
endmodule

bind banked_spad spad_checks #(.LANES(LANES)) u_checks (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .laneMask  (laneMask),
  .doneValid (doneValid),
  .passCount (passCount)
);

// File: tb/tb_banked_spad.sv
module tb_banked_spad;
  localparam int LANES = 16;
  localparam int AW    = 8;
  localparam int WW    = 32;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 reqValid, reqReady, reqWrite, doneValid;
  logic [LANES-1:0]     laneMask;
  logic [LANES*AW-1:0]  laneAddr;
  logic [LANES*WW-1:0]  laneWdata;
  logic [LANES*WW-1:0]  rdData;
  logic [4:0]           passCount;

  int compared = 0;
  int mismatched = 0;
  logic [WW-1:0] refMem [256];
  logic [AW-1:0] bAddr [LANES];
  logic [WW-1:0] bData [LANES];
  logic [31:0]   seed = 32'h1234_5678;

  always #4 clk = ~clk;

  banked_spad dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .laneMask(laneMask), .laneAddr(laneAddr),
    .laneWdata(laneWdata), .doneValid(doneValid), .rdData(rdData),
    .passCount(passCount)
  );

  function automatic logic [31:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // largest number of distinct addresses any bank sees among active lanes
  function automatic int expectPasses(input logic [LANES-1:0] mask);
    int perBank [16];
    int best = 0;
    for (int b = 0; b < 16; b++) perBank[b] = 0;
    for (int i = 0; i < LANES; i++) begin
      bit fresh = mask[i];
      for (int j = 0; j < i; j++)
        if (mask[j] && bAddr[j] == bAddr[i]) fresh = 0;
      if (fresh) perBank[bAddr[i][3:0]]++;
    end
    for (int b = 0; b < 16; b++) if (perBank[b] > best) best = perBank[b];
    return best;
  endfunction

  task automatic runBatch(input string tag, input logic wr, input logic [LANES-1:0] mask);
    int expP, cyc;
    bit busyOk;
    logic [WW-1:0] expRd [LANES];
    expP = expectPasses(mask);
    for (int i = 0; i < LANES; i++)
      expRd[i] = (!wr && mask[i]) ? refMem[bAddr[i]] : '0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; laneMask = mask;
    for (int i = 0; i < LANES; i++) begin
      laneAddr[i*AW +: AW]  = bAddr[i];
      laneWdata[i*WW +: WW] = bData[i];
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0; busyOk = 1;
    while (!doneValid && cyc < 200) begin
      if (reqReady) busyOk = 0;
      @(negedge clk);
      cyc++;
    end
    check({tag, " R4 pass count"}, 32'(passCount), 32'(expP));
    check("R5 completion latency", 32'(cyc), 32'(2 * expP));
    if (expP > 0) check("R6 ready low while busy", 32'(busyOk), 32'd1);
    check("R6 ready back at done", 32'(reqReady), 32'd1);
    for (int i = 0; i < LANES; i++) begin
      if (!mask[i]) check("R8 inactive lane reads zero", rdData[i*WW +: WW], 32'd0);
      else if (!wr) check({tag, " read data"}, rdData[i*WW +: WW], expRd[i]);
    end
    @(negedge clk);
    check("R5 done is one cycle", 32'(doneValid), 32'd0);
    check("R10 count holds", 32'(passCount), 32'(expP));
    if (wr)
      for (int i = 0; i < LANES; i++) if (mask[i]) refMem[bAddr[i]] = bData[i];
  endtask

  task automatic strided(input int base, input int stride);
    for (int i = 0; i < LANES; i++) begin
      bAddr[i] = AW'(base + stride * i);
      bData[i] = nextRand();
    end
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    laneMask = '0; laneAddr = '0; laneWdata = '0;
    repeat (3) @(negedge clk);
    check("R10 reset pass count", 32'(passCount), 32'd0);
    check("R5 reset done low", 32'(doneValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R6 ready after reset", 32'(reqReady), 32'd1);

    // R1: fill every word with stride-1 writes (conflict-free, R2)
    for (int r = 0; r < 16; r++) begin
      strided(16 * r, 1);
      runBatch("R2", 1'b1, 16'hFFFF);
    end
    for (int r = 0; r < 16; r++) begin
      strided(16 * r + 3, 1);
      runBatch("R1", 1'b0, 16'hFFFF);
    end

    // stride sweep over reads and writes (R4)
    for (int s = 0; s < 34; s++) begin
      for (int base = 0; base < 2; base++) begin
        strided(base * 7, s);
        runBatch("R4", 1'b1, 16'hFFFF);
        runBatch("R4", 1'b0, 16'hFFFF);
      end
    end

    // permutation of banks is conflict free (R2)
    for (int i = 0; i < LANES; i++) begin
      bAddr[i] = AW'(((i * 5 + 3) % 16) + 16 * (i % 4));
      bData[i] = nextRand();
    end
    runBatch("R2", 1'b0, 16'hFFFF);

    // broadcast read (R3)
    for (int i = 0; i < LANES; i++) bAddr[i] = 8'hA7;
    runBatch("R3", 1'b0, 16'hFFFF);

    // same-address writes: highest lane wins (R7)
    for (int i = 0; i < LANES; i++) begin
      bAddr[i] = 8'h42;
      bData[i] = 32'hC0DE_0000 + 32'(i);
    end
    runBatch("R7", 1'b1, 16'h0F3C);
    runBatch("R7", 1'b0, 16'hFFFF);
    check("R7 highest lane stored", refMem[8'h42], 32'hC0DE_000B);

    // masked-out conflicting lanes are ignored (R8)
    strided(0, 16);
    runBatch("R8", 1'b1, 16'h0001);
    runBatch("R8", 1'b0, 16'h0101);

    // empty batch (R9)
    runBatch("R9", 1'b0, 16'h0000);
    runBatch("R9", 1'b1, 16'h0000);

    // random addresses and masks
    for (int n = 0; n < 60; n++) begin
      logic [31:0] m;
      for (int i = 0; i < LANES; i++) begin
        bAddr[i] = AW'(nextRand());
        bData[i] = nextRand();
      end
      m = nextRand();
      runBatch("R4", m[31], m[15:0]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule